// File: doc/BRIEF.md
# Video pixel output formatter

The formatter sits at the end of a video decode path. Each output sample period lasts two clocks. In each period an upstream stage presents one 4:2:2 sample: luma, one chroma component (Cb or Cr, with a flag naming which), an 8-bit-per-component RGB triple, and the blanking, VBI, horizontal sync and vertical sync flags. The upstream stage marks the sample with a one-clock strobe. The formatter captures the sample and drives a 16-bit parallel pixel bus in the selected layout. The layouts are two YCbCr widths, a byte stream with BT.656 code protection, and two packed RGB widths. Outside active video, the formatter substitutes fixed blank-level codes unless VBI data is being carried.

The formatter also makes a data-valid qualifier. A latency bit and a duty bit pick one of three timing modes. Polarity bits set how the data-valid and VBI-valid outputs are driven. The sync and blank outputs travel through the same registers as the pixel data, so they stay aligned with it. Every output changes only on the rising clock edge. The polarity and mode inputs are treated as static configuration.

Top module: `pix_out_fmt`

## Requirements
- R1: While reset is held low, the outputs are as follows: pixel word 0, data-valid 0, VBI-valid 0, blank 1, hsync 0 and vsync 0.
- R2: A sample is captured on a clock where the strobe is high. The first output word for that sample, and its blank, sync and VBI flags, appear after the second rising edge. The second word appears after the third edge.
- R3: Format code 000 gives the 16-bit YCbCr layout: luma in bits 15:8 and chroma in bits 7:0. The same word is held for both clocks. In active video, chroma is limited to the range 16 to 240. Format codes 101, 110 and 111 behave like 000.
- R4: Format code 001 gives the 8-bit layout. Bits 15:8 carry the chroma byte in the first clock and the luma byte in the second, and bits 7:0 are 0. Across two samples this gives the order Cb, Y, Cr, Y. Chroma is limited as in R3.
- R5: Format code 010 behaves like 001. In addition, in active video an output byte of 0x00 becomes 0x01 and a byte of 0xFF becomes 0xFE.
- R6: Format code 011 gives {0, R[7:3], G[7:3], B[7:3]}. Format code 100 gives {R[7:3], G[7:2], B[7:3]}.
- R7: When blank is high and VBI is low, the YCbCr formats output Y = 0x10 and chroma = 0x80. In the 8-bit formats this is 0x80 in the first clock and 0x10 in the second. The RGB formats output 0.
- R8: When blank and VBI are both high, the input data passes through without limiting, protection or blank codes.
- R9: With latency bit 0 and duty bit 0, data-valid is active in the second clock of each sample period and never while blanking.
- R10: With latency bit 0 and duty bit 1, data-valid is active in the second clock of every period and also in the first clock of a Cr sample. It is never active while blanking.
- R11: With the latency bit at 1, data-valid is active in both clocks of every period outside blanking.
- R12: The data-valid and VBI-valid outputs are active high when their polarity bit is 1 and active low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the output sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Marks the clock carrying a new sample |
| in_y | input | 8 | Luma |
| in_c | input | 8 | Chroma, Cb or Cr |
| in_cr | input | 1 | 1 when in_c is Cr |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_blank | input | 1 | Sample lies in a blanking interval |
| in_vbi | input | 1 | Sample carries VBI data |
| in_hsync | input | 1 | Horizontal sync flag |
| in_vsync | input | 1 | Vertical sync flag |
| fmt_sel | input | 3 | Output format code |
| dv_lat | input | 1 | Data-valid latency bit (continuous mode) |
| dv_dcyc | input | 1 | Data-valid duty bit (legacy mode) |
| dv_pol | input | 1 | Data-valid polarity |
| vbi_pol | input | 1 | VBI-valid polarity |
| pix_out | output | 16 | Pixel bus |
| dv_out | output | 1 | Data-valid qualifier |
| vbi_out | output | 1 | VBI-valid flag |
| blank_out | output | 1 | Blank flag aligned to the pixel bus |
| hs_out | output | 1 | Horizontal sync aligned to the pixel bus |
| vs_out | output | 1 | Vertical sync aligned to the pixel bus |

## Verification
The only internal state is the captured sample and the half-period phase bit. A phase error shows up within one clock: the chroma and luma bytes swap in the 8-bit formats, and data-valid pulses land in the wrong clock. A lost or stale sample register shows up two clocks after the strobe, as a word or sync flag that does not match the stimulus. Wrong blank handling appears in the first blanked period as a non-blank code or a data-valid pulse.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  localparam int CMP_W = 8;
  localparam int PIX_W = 2 * CMP_W;

  localparam logic [2:0] FMT_YC16  = 3'd0;
  localparam logic [2:0] FMT_YC8   = 3'd1;
  localparam logic [2:0] FMT_BT656 = 3'd2;
  localparam logic [2:0] FMT_RGB15 = 3'd3;
  localparam logic [2:0] FMT_RGB16 = 3'd4;

  localparam logic [CMP_W-1:0] CHROMA_LO = 8'd16;
  localparam logic [CMP_W-1:0] CHROMA_HI = 8'd240;
  localparam logic [CMP_W-1:0] BLANK_Y   = 8'h10;
  localparam logic [CMP_W-1:0] BLANK_C   = 8'h80;

  typedef struct packed {
    logic [CMP_W-1:0] y;
    logic [CMP_W-1:0] c;
    logic [CMP_W-1:0] r;
    logic [CMP_W-1:0] g;
    logic [CMP_W-1:0] b;
    logic             cr;
    logic             blank;
    logic             vbi;
    logic             hs;
    logic             vs;
  } pxf_sample_t;

  function automatic logic [CMP_W-1:0] limit_chroma(input logic [CMP_W-1:0] v);
    if (v < CHROMA_LO)      return CHROMA_LO;
    else if (v > CHROMA_HI) return CHROMA_HI;
    else                    return v;
  endfunction

  function automatic logic [CMP_W-1:0] protect_code(input logic [CMP_W-1:0] v);
    if (v == '0)      return 8'h01;
    else if (v == '1) return 8'hFE;
    else              return v;
  endfunction

  function automatic logic [PIX_W-1:0] pack555(input logic [CMP_W-1:0] r,
                                               input logic [CMP_W-1:0] g,
                                               input logic [CMP_W-1:0] b);
    return {1'b0, r[CMP_W-1 -: 5], g[CMP_W-1 -: 5], b[CMP_W-1 -: 5]};
  endfunction

  function automatic logic [PIX_W-1:0] pack565(input logic [CMP_W-1:0] r,
                                               input logic [CMP_W-1:0] g,
                                               input logic [CMP_W-1:0] b);
    return {r[CMP_W-1 -: 5], g[CMP_W-1 -: 6], b[CMP_W-1 -: 5]};
  endfunction
endpackage

// File: rtl/pxf_capture.sv
module pxf_capture
  import pxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_stb,
  input  pxf_sample_t in_smp,
  output pxf_sample_t smp_q,
  output logic        ph_q
);
  // ph_q = 0: first clock of a sample period, 1: second clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q       <= '0;
      smp_q.blank <= 1'b1;
      ph_q        <= 1'b1;
    end else begin
      if (in_stb) smp_q <= in_smp;
      ph_q <= !in_stb;
    end
  end

  // R2: the first half of a period only follows a strobe
  assert_phase_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q |-> $past(in_stb));
endmodule

// File: rtl/pxf_format.sv
module pxf_format
  import pxf_pkg::*;
(
  input  logic [2:0]       fmt_sel,
  input  logic             ph,
  input  logic [CMP_W-1:0] y,
  input  logic [CMP_W-1:0] c,
  input  logic [CMP_W-1:0] r,
  input  logic [CMP_W-1:0] g,
  input  logic [CMP_W-1:0] b,
  input  logic             blank,
  input  logic             vbi,
  output logic [PIX_W-1:0] word
);
  logic             forced;
  logic [CMP_W-1:0] c_eff;
  logic [CMP_W-1:0] byte_sel;

  assign forced = blank && !vbi;
  assign c_eff  = blank ? c : limit_chroma(c);

  always_comb begin
    byte_sel = ph ? y : c_eff;
    if (forced) byte_sel = ph ? BLANK_Y : BLANK_C;
    else if (!blank && fmt_sel == FMT_BT656) byte_sel = protect_code(byte_sel);
  end

  always_comb begin
    case (fmt_sel)
      FMT_YC8, FMT_BT656: word = {byte_sel, {CMP_W{1'b0}}};
      FMT_RGB15:          word = forced ? '0 : pack555(r, g, b);
      FMT_RGB16:          word = forced ? '0 : pack565(r, g, b);
      default:            word = forced ? {BLANK_Y, BLANK_C} : {y, c_eff};
    endcase
  end

  // R7: RGB formats drive zero during plain blanking
  always_comb begin
    if (forced && (fmt_sel == FMT_RGB15 || fmt_sel == FMT_RGB16))
      assert_rgb_blank_zero_R7: assert (word == '0);
  end
endmodule

// File: rtl/pxf_valid.sv
module pxf_valid (
  input  logic blank,
  input  logic cr,
  input  logic ph,
  input  logic lat,
  input  logic dcyc,
  output logic dv_act
);
  logic slot_hit;
  // continuous mode, second-clock slot, or extra Cr slot in legacy mode
  assign slot_hit = lat || ph || (dcyc && cr);
  assign dv_act   = !blank && slot_hit;
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_stb,
  input  logic [CMP_W-1:0] in_y,
  input  logic [CMP_W-1:0] in_c,
  input  logic             in_cr,
  input  logic [CMP_W-1:0] in_r,
  input  logic [CMP_W-1:0] in_g,
  input  logic [CMP_W-1:0] in_b,
  input  logic             in_blank,
  input  logic             in_vbi,
  input  logic             in_hsync,
  input  logic             in_vsync,
  input  logic [2:0]       fmt_sel,
  input  logic             dv_lat,
  input  logic             dv_dcyc,
  input  logic             dv_pol,
  input  logic             vbi_pol,
  output logic [PIX_W-1:0] pix_out,
  output logic             dv_out,
  output logic             vbi_out,
  output logic             blank_out,
  output logic             hs_out,
  output logic             vs_out
);
  pxf_sample_t      in_smp;
  pxf_sample_t      smp_q;
  logic             ph_q;
  logic [PIX_W-1:0] word_nxt;
  logic             dv_act;
  logic             dv_raw_q;

  assign in_smp = '{y: in_y, c: in_c, r: in_r, g: in_g, b: in_b, cr: in_cr,
                    blank: in_blank, vbi: in_vbi, hs: in_hsync, vs: in_vsync};

  pxf_capture u_capture (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_smp(in_smp),
    .smp_q(smp_q), .ph_q(ph_q)
  );

  pxf_format u_format (
    .fmt_sel(fmt_sel), .ph(ph_q), .y(smp_q.y), .c(smp_q.c),
    .r(smp_q.r), .g(smp_q.g), .b(smp_q.b),
    .blank(smp_q.blank), .vbi(smp_q.vbi), .word(word_nxt)
  );

  pxf_valid u_valid (
    .blank(smp_q.blank), .cr(smp_q.cr), .ph(ph_q),
    .lat(dv_lat), .dcyc(dv_dcyc), .dv_act(dv_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out   <= '0;
      dv_raw_q  <= 1'b0;
      dv_out    <= 1'b0;
      vbi_out   <= 1'b0;
      blank_out <= 1'b1;
      hs_out    <= 1'b0;
      vs_out    <= 1'b0;
    end else begin
      pix_out   <= word_nxt;
      dv_raw_q  <= dv_act;
      dv_out    <= dv_pol ? dv_act : !dv_act;
      vbi_out   <= vbi_pol ? smp_q.vbi : !smp_q.vbi;
      blank_out <= smp_q.blank;
      hs_out    <= smp_q.hs;
      vs_out    <= smp_q.vs;
    end
  end

  assert_no_valid_in_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_out |-> !dv_raw_q);

  assert_continuous_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dv_lat) && !blank_out) |-> dv_raw_q);

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_stb, 2) |-> (hs_out == $past(in_hsync, 2) && vs_out == $past(in_vsync, 2)));

  assert_chroma_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt_sel) == FMT_YC16 && !blank_out) |->
      (pix_out[CMP_W-1:0] >= CHROMA_LO && pix_out[CMP_W-1:0] <= CHROMA_HI));
endmodule

// File: tb/pix_out_fmt_tb.sv
module pix_out_fmt_tb;
  typedef struct {
    logic [7:0] y, c, r, g, b;
    logic cr, blank, vbi, hs, vs;
  } smp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic in_stb = 0;
  logic [7:0] in_y = 0, in_c = 0, in_r = 0, in_g = 0, in_b = 0;
  logic in_cr = 0, in_blank = 0, in_vbi = 0, in_hsync = 0, in_vsync = 0;
  logic [2:0] fmt_sel = 0;
  logic dv_lat = 0, dv_dcyc = 0, dv_pol = 1, vbi_pol = 1;
  logic [15:0] pix_out;
  logic dv_out, vbi_out, blank_out, hs_out, vs_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pix_out_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_y(in_y), .in_c(in_c),
    .in_cr(in_cr), .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_blank(in_blank),
    .in_vbi(in_vbi), .in_hsync(in_hsync), .in_vsync(in_vsync), .fmt_sel(fmt_sel),
    .dv_lat(dv_lat), .dv_dcyc(dv_dcyc), .dv_pol(dv_pol), .vbi_pol(vbi_pol),
    .pix_out(pix_out), .dv_out(dv_out), .vbi_out(vbi_out), .blank_out(blank_out),
    .hs_out(hs_out), .vs_out(vs_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h fmt=%0d t=%0t", req, act, exp, fmt_sel, $time);
    end
  endtask

  function automatic logic [7:0] lim(input logic [7:0] v);
    return (v < 8'd16) ? 8'd16 : (v > 8'd240) ? 8'd240 : v;
  endfunction

  function automatic logic [15:0] exp_pix(input smp_t s, input bit second, input logic [2:0] f);
    bit plain_blank = s.blank && !s.vbi;
    logic [7:0] cc = s.blank ? s.c : lim(s.c);
    logic [7:0] bt;
    case (f)
      3'd1, 3'd2: begin
        if (plain_blank) bt = second ? 8'h10 : 8'h80;
        else bt = second ? s.y : cc;
        if (f == 3'd2 && !s.blank) begin
          if (bt == 8'h00) bt = 8'h01;
          if (bt == 8'hFF) bt = 8'hFE;
        end
        return {bt, 8'h00};
      end
      3'd3: return plain_blank ? 16'h0 : {1'b0, s.r[7:3], s.g[7:3], s.b[7:3]};
      3'd4: return plain_blank ? 16'h0 : {s.r[7:3], s.g[7:2], s.b[7:3]};
      default: return plain_blank ? 16'h1080 : {s.y, cc};
    endcase
  endfunction

  function automatic logic exp_dv(input smp_t s, input bit second);
    logic v;
    if (s.blank) v = 0;
    else if (dv_lat) v = 1;
    else if (dv_dcyc) v = second || s.cr;
    else v = second;
    return dv_pol ? v : !v;
  endfunction

  function automatic string dv_req();
    return dv_lat ? "R11" : dv_dcyc ? "R10" : "R9";
  endfunction

  task automatic check_all(input smp_t s, input bit second);
    string rq;
    rq = (fmt_sel == 3'd3 || fmt_sel == 3'd4) ? "R6" :
         (fmt_sel == 3'd1) ? "R4" : (fmt_sel == 3'd2) ? "R5" : "R3";
    if (s.blank && !s.vbi) rq = "R7";
    else if (s.blank) rq = "R8";
    check(rq, pix_out, exp_pix(s, second, fmt_sel));
    check(dv_req(), {15'b0, dv_out}, {15'b0, exp_dv(s, second)});
    check(dv_pol ? dv_req() : "R12", {15'b0, dv_out}, {15'b0, exp_dv(s, second)});
    check("R12", {15'b0, vbi_out}, {15'b0, vbi_pol ? s.vbi : !s.vbi});
    check("R2", {13'b0, blank_out, hs_out, vs_out}, {13'b0, s.blank, s.hs, s.vs});
  endtask

  task automatic drive(input smp_t s);
    in_stb = 1; in_y = s.y; in_c = s.c; in_r = s.r; in_g = s.g; in_b = s.b;
    in_cr = s.cr; in_blank = s.blank; in_vbi = s.vbi; in_hsync = s.hs; in_vsync = s.vs;
  endtask

  function automatic logic [7:0] rnd_byte();
    int k = $urandom_range(0, 7);
    if (k == 0) return 8'h00;
    if (k == 1) return 8'hFF;
    if (k == 2) return 8'd5;
    if (k == 3) return 8'd250;
    return 8'($urandom);
  endfunction

  smp_t prev, cur;
  bit cr_toggle;

  // one sample period: check previous sample second word, then current first word
  task automatic period(input smp_t s);
    drive(s);
    @(negedge clk);
    check_all(prev, 1'b1);
    in_stb = 0;
    @(negedge clk);
    check_all(s, 1'b0);
    prev = s;
  endtask

  initial begin
    void'($urandom(32'd1234));
    prev = '{y: 0, c: 0, r: 0, g: 0, b: 0, cr: 0, blank: 1, vbi: 0, hs: 0, vs: 0};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", pix_out, 16'h0);
    check("R1", {11'b0, dv_out, vbi_out, blank_out, hs_out, vs_out}, 16'b00100);
    rst_n = 1;

    // directed corners
    fmt_sel = 3'd1;
    cur = '{y: 8'hFF, c: 8'h03, r: 0, g: 0, b: 0, cr: 0, blank: 0, vbi: 0, hs: 1, vs: 0};
    period(cur);                       // R4: chroma limited to 16, luma 0xFF passes
    cur.cr = 1; cur.c = 8'hF8; cur.hs = 0;
    period(cur);
    fmt_sel = 3'd2;
    cur.y = 8'h00; cur.c = 8'h00;
    period(cur);                       // R5: luma 00 protected to 01
    cur.y = 8'hFF;
    period(cur);                       // R5: luma FF protected to FE
    cur.blank = 1; cur.vbi = 1; cur.y = 8'h00;
    period(cur);                       // R8: raw during VBI
    fmt_sel = 3'd4; cur.vbi = 0; cur.r = 8'hFF; cur.g = 8'hFF; cur.b = 8'hFF;
    period(cur);                       // R7: RGB zero in blanking
    fmt_sel = 3'd6; cur.blank = 0; cur.c = 8'hFF; cur.y = 8'h42;
    period(cur);                       // R3: reserved code behaves as 16-bit

    // random blocks over formats and valid modes
    for (int blk = 0; blk < 48; blk++) begin
      fmt_sel = 3'(blk % 8);
      dv_lat  = ((blk / 8) % 3) == 2;
      dv_dcyc = ((blk / 8) % 3) == 1;
      dv_pol  = 1'($urandom);
      vbi_pol = 1'($urandom);
      for (int i = 0; i < 40; i++) begin
        cr_toggle = !cr_toggle;
        cur.y = rnd_byte(); cur.c = rnd_byte();
        cur.r = rnd_byte(); cur.g = rnd_byte(); cur.b = rnd_byte();
        cur.cr = cr_toggle;
        cur.blank = ($urandom_range(0, 3) == 0);
        cur.vbi = cur.blank && ($urandom_range(0, 1) == 1);
        cur.hs = 1'($urandom); cur.vs = 1'($urandom);
        period(cur);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule